// File: doc/BRIEF.md
# Priority-Based Reference Input Selector

This block decides which of two reference clock inputs is steered into a downstream phase-locked loop. It produces a registered mux select and a per-input active indication. Loss-of-signal flags for both inputs come from a separate monitor. The block itself does not drive or examine the clocks.

The block has a manual mode and an automatic mode. In manual mode, a register code or an external select pin names the input. A pin-control enable decides which of the two is used. In automatic mode, two rank fields list the preferred input first and the fallback second. The block then picks the best-ranked input that still has signal. A switch in automatic mode waits for a programmable hysteresis count, so that a flapping loss flag does not toggle the selection.

The active indication for input A can also be presented on a pin with programmable polarity. That pin is enabled only while the pin-controlled manual selection is in force.

Top module: `clk_src_select`

## Requirements
- R1: While `rst_n` is low, `mux_sel` is 0, which selects input A, and the internal hysteresis count is cleared.
- R2: The mode code 00 means manual and codes 01, 10 and 11 mean automatic. In manual mode with `pin_ctl_en`=0, `man_code` 01 selects input B and codes 00, 10 and 11 select input A. `mux_sel` takes the new value at the first rising edge after the inputs change.
- R3: In manual mode with `pin_ctl_en`=1, `sel_pin`=1 selects input B and `sel_pin`=0 selects input A. `man_code` is ignored. The latency is the same one edge.
- R4: In manual mode the loss flags have no effect on `mux_sel`.
- R5: Each rank field names an input: code 01 means input B and codes 00, 10 and 11 mean input A. In automatic mode the candidate is the `rank_hi` input if its loss flag is 0. Otherwise it is the `rank_lo` input if that input's loss flag is 0.
- R6: In automatic mode, if neither named input is free of loss of signal, `mux_sel` holds its value.
- R7: In automatic mode with `hyst_dly`=D, a candidate that differs from the current input replaces it at the (D+1)-th consecutive rising edge at which it differs. Any edge at which the candidate equals the current input restarts the count. Entering automatic mode from manual mode starts the count from zero.
- R8: `active[0]` (input A) and `active[1]` (input B) each read 1 only when that input is selected and its `los` bit is 0. The vector is therefore one-hot or all zero.
- R9: `act_a_oe` is 1 exactly in manual mode with `pin_ctl_en`=1. While it is 1, `act_a_pin` equals `active[0]` when `act_pol`=1 and its inverse when `act_pol`=0. While it is 0, `act_a_pin` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Selection method, 00 manual, else automatic |
| pin_ctl_en | input | 1 | Manual choice taken from `sel_pin` when 1 |
| man_code | input | 2 | Register-based manual choice |
| sel_pin | input | 1 | External manual select, 1 = input B |
| rank_hi | input | 2 | First-priority input code |
| rank_lo | input | 2 | Second-priority input code |
| los | input | 2 | Loss-of-signal flags, bit 0 input A, bit 1 input B |
| hyst_dly | input | 5 | Automatic switch hysteresis count |
| act_pol | input | 1 | Polarity of `act_a_pin`, 1 = active high |
| mux_sel | output | 1 | Registered select, 0 = input A, 1 = input B |
| active | output | 2 | Per-input active status |
| act_a_pin | output | 1 | Input A active status for a pin |
| act_a_oe | output | 1 | Output enable for `act_a_pin` |

## Verification
The hardest case to reach is an automatic switch that depends on both the starting selection and the hysteresis count. It is also hard to reach the case where a lost-both condition must freeze a selection that automatic mode itself would not have chosen. The stimulus first forces a known selection through manual mode, which also clears the count. It then enters automatic mode with a chosen loss pattern. Under that pattern every rank code, loss pattern, starting input and automatic mode code is swept, and every hysteresis value from 0 to 31 is stepped edge by edge. An interrupted-count sequence confirms that the count restarts.

// File: rtl/ssel_pkg.sv
package ssel_pkg;
  typedef enum logic {SRC_A = 1'b0, SRC_B = 1'b1} src_t;

  localparam int CODE_W = 2;
  localparam logic [CODE_W-1:0] MODE_MANUAL = 2'b00;
  localparam logic [CODE_W-1:0] CODE_B      = 2'b01;

  function automatic src_t code_to_src(input logic [CODE_W-1:0] code);
    return (code == CODE_B) ? SRC_B : SRC_A;
  endfunction
endpackage

// File: rtl/ssel_pick.sv
module ssel_pick
  import ssel_pkg::*;
(
  input  logic [CODE_W-1:0] mode,
  input  logic              pin_ctl_en,
  input  logic [CODE_W-1:0] man_code,
  input  logic              sel_pin,
  input  logic [CODE_W-1:0] rank_hi,
  input  logic [CODE_W-1:0] rank_lo,
  input  logic [1:0]        los,
  input  src_t              cur,
  output logic              is_auto,
  output src_t              target
);
  src_t man_src, hi_src, lo_src;

  always_comb begin
    is_auto = (mode != MODE_MANUAL);
    man_src = pin_ctl_en ? (sel_pin ? SRC_B : SRC_A) : code_to_src(man_code);
    hi_src  = code_to_src(rank_hi);
    lo_src  = code_to_src(rank_lo);
    if (!is_auto)                  target = man_src;
    else if (!los[int'(hi_src)])   target = hi_src;
    else if (!los[int'(lo_src)])   target = lo_src;
    else                           target = cur;
  end
endmodule

// File: rtl/ssel_hold.sv
module ssel_hold
  import ssel_pkg::*;
#(
  parameter int HYST_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_auto,
  input  src_t              target,
  input  logic [HYST_W-1:0] hyst_dly,
  output src_t              cur
);
  localparam logic [HYST_W-1:0] CNT_ONE = HYST_W'(1);

  src_t              sel_q, sel_d;
  logic [HYST_W-1:0] cnt_q, cnt_d;
  logic              upd_en;

  always_comb begin
    sel_d = sel_q;
    cnt_d = cnt_q;
    if (!is_auto) begin
      sel_d = target;
      cnt_d = '0;
    end else if (target == sel_q) begin
      cnt_d = '0;
    end else if (cnt_q == hyst_dly) begin
      sel_d = target;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_ONE;
    end
    upd_en = (sel_d != sel_q) || (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SRC_A;
      cnt_q <= '0;
    end else if (upd_en) begin
      sel_q <= sel_d;
      cnt_q <= cnt_d;
    end
  end

  assign cur = sel_q;

  // R2, R3: manual choice lands one edge later
  a_r2_manual_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !is_auto |=> (sel_q == $past(target)));

  // R7: no automatic switch before the hysteresis count expires
  a_r7_no_early_switch: assert property (@(posedge clk) disable iff (!rst_n)
    (is_auto && target != sel_q && cnt_q < hyst_dly) |=> $stable(sel_q));
endmodule

// File: rtl/ssel_status.sv
module ssel_status
  import ssel_pkg::*;
#(
  parameter int NUM_IN = 2
) (
  input  src_t              cur,
  input  logic [NUM_IN-1:0] los,
  input  logic              pin_en,
  input  logic              act_pol,
  output logic [NUM_IN-1:0] active,
  output logic              act_a_pin,
  output logic              act_a_oe
);
  for (genvar i = 0; i < NUM_IN; i++) begin : g_act
    assign active[i] = (int'(cur) == i) && !los[i];
  end

  assign act_a_oe  = pin_en;
  assign act_a_pin = pin_en && (active[0] == act_pol);
endmodule

// File: rtl/clk_src_select.sv
module clk_src_select
  import ssel_pkg::*;
#(
  parameter int HYST_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              pin_ctl_en,
  input  logic [1:0]        man_code,
  input  logic              sel_pin,
  input  logic [1:0]        rank_hi,
  input  logic [1:0]        rank_lo,
  input  logic [1:0]        los,
  input  logic [HYST_W-1:0] hyst_dly,
  input  logic              act_pol,
  output logic              mux_sel,
  output logic [1:0]        active,
  output logic              act_a_pin,
  output logic              act_a_oe
);
  localparam int NUM_IN = 2;

  logic is_auto;
  src_t target, cur;

  ssel_pick u_pick (
    .mode(mode), .pin_ctl_en(pin_ctl_en), .man_code(man_code), .sel_pin(sel_pin),
    .rank_hi(rank_hi), .rank_lo(rank_lo), .los(los), .cur(cur),
    .is_auto(is_auto), .target(target)
  );

  ssel_hold #(.HYST_W(HYST_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .is_auto(is_auto), .target(target),
    .hyst_dly(hyst_dly), .cur(cur)
  );

  ssel_status #(.NUM_IN(NUM_IN)) u_stat (
    .cur(cur), .los(los), .pin_en(!is_auto && pin_ctl_en), .act_pol(act_pol),
    .active(active), .act_a_pin(act_a_pin), .act_a_oe(act_a_oe)
  );

  assign mux_sel = (cur == SRC_B);

  // R8: at most one active input
  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(active));

  // R8: a lost input never reads active
  a_r8_lost_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    (active & los) == 2'b00);

  // R9: pin enabled only under pin-controlled manual selection
  a_r9_pin_oe: assert property (@(posedge clk) disable iff (!rst_n)
    act_a_oe |-> (mode == MODE_MANUAL && pin_ctl_en));

  // R6: both inputs lost in automatic mode freezes the select
  a_r6_hold_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_MANUAL && los == 2'b11) |=> $stable(mux_sel));
endmodule

// File: tb/sim_clk_src_select.sv
module sim_clk_src_select;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode, man_code, rank_hi, rank_lo, los;
  logic       pin_ctl_en, sel_pin, act_pol;
  logic [4:0] hyst_dly;
  logic       mux_sel, act_a_pin, act_a_oe;
  logic [1:0] active;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clk_src_select u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pin_ctl_en(pin_ctl_en),
    .man_code(man_code), .sel_pin(sel_pin), .rank_hi(rank_hi), .rank_lo(rank_lo),
    .los(los), .hyst_dly(hyst_dly), .act_pol(act_pol),
    .mux_sel(mux_sel), .active(active), .act_a_pin(act_a_pin), .act_a_oe(act_a_oe)
  );

  task automatic chk(input int act, input int exp, input string req);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic int exp_act(input int s, input logic [1:0] l);
    return (s == 0) ? (l[0] ? 0 : 1) : (l[1] ? 0 : 2);
  endfunction

  task automatic force_sel(input int s);
    mode = 2'b00; pin_ctl_en = 1'b0; man_code = (s == 1) ? 2'b01 : 2'b00;
    step();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 2'b00; pin_ctl_en = 1'b0; man_code = 2'b01; sel_pin = 1'b1;
    rank_hi = 2'b00; rank_lo = 2'b01; los = 2'b00; hyst_dly = 5'd0; act_pol = 1'b1;
    repeat (3) step();
    // R1: reset state
    chk(mux_sel, 0, "R1");
    chk(active, 1, "R1");
    rst_n = 1'b1;
    step();
    chk(mux_sel, 1, "R2");

    // R2 R3 R4 R9: manual sweep
    for (int pc = 0; pc < 2; pc++)
      for (int mc = 0; mc < 4; mc++)
        for (int sp = 0; sp < 2; sp++)
          for (int l = 0; l < 4; l++)
            for (int pol = 0; pol < 2; pol++) begin
              int es, ea;
              force_sel(1 - ((pc == 1) ? sp : ((mc == 1) ? 1 : 0)));
              mode = 2'b00; pin_ctl_en = pc[0]; man_code = mc[1:0];
              sel_pin = sp[0]; los = l[1:0]; act_pol = pol[0];
              step();
              es = (pc == 1) ? sp : ((mc == 1) ? 1 : 0);
              ea = exp_act(es, l[1:0]);
              chk(mux_sel, es, pc ? "R3" : "R2");
              chk(mux_sel, es, "R4");
              chk(active, ea, "R8");
              chk(act_a_oe, pc, "R9");
              chk(act_a_pin, pc ? ((ea[0] == pol[0]) ? 1 : 0) : 0, "R9");
              los = 2'b00;
            end

    // R5 R6 R8 R9: automatic sweep, hysteresis 0
    hyst_dly = 5'd0;
    for (int md = 1; md < 4; md++)
      for (int h = 0; h < 4; h++)
        for (int lo = 0; lo < 4; lo++)
          for (int l = 0; l < 4; l++)
            for (int s = 0; s < 2; s++) begin
              int rh, rl, es;
              los = 2'b00;
              force_sel(s);
              rh = (h == 1) ? 1 : 0; rl = (lo == 1) ? 1 : 0;
              mode = md[1:0]; rank_hi = h[1:0]; rank_lo = lo[1:0]; los = l[1:0];
              pin_ctl_en = 1'b1;
              step();
              if (!l[rh]) es = rh; else if (!l[rl]) es = rl; else es = s;
              chk(mux_sel, es, (l[rh] && l[rl]) ? "R6" : "R5");
              chk(active, exp_act(es, l[1:0]), "R8");
              chk(act_a_oe, 0, "R9");
              chk(act_a_pin, 0, "R9");
            end

    // R7: every hysteresis value
    rank_hi = 2'b00; rank_lo = 2'b01;
    for (int d = 0; d < 32; d++) begin
      los = 2'b00;
      force_sel(0);
      mode = 2'b10; hyst_dly = d[4:0]; los = 2'b01;
      for (int k = 0; k < d; k++) begin
        step();
        chk(mux_sel, 0, "R7");
      end
      step();
      chk(mux_sel, 1, "R7");
    end

    // R7: interrupted count restarts
    los = 2'b00;
    force_sel(0);
    mode = 2'b11; hyst_dly = 5'd4; los = 2'b01;
    repeat (3) step();
    chk(mux_sel, 0, "R7");
    los = 2'b00;
    step();
    chk(mux_sel, 0, "R7");
    los = 2'b01;
    repeat (4) step();
    chk(mux_sel, 0, "R7");
    step();
    chk(mux_sel, 1, "R7");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule